// File: doc/BRIEF.md
# CCD frame-transfer timing generator

This block is a clocked sequencer that produces the gate-control strobes for a frame-transfer CCD image sensor. It runs one exposure cycle after another. Each cycle first drains the pixel wells through the overflow-drain clear strobe. It then waits for a programmable integration time and moves the image charge into the storage area with parallel pulses. Finally it reads the storage area line by line through one or two serial registers. The per-pixel reset, clamp and sample-and-hold strobes needed for correlated double sampling come out aligned with the serial gate.

A two-bit mode input picks one of four readout schemes: interlaced, progressive scan through one register, progressive scan through both registers, or line summing. The mode and the integration length are captured once, at the start of each frame. A field flag alternates between frames. In interlaced and line-summing operation it sets the number of parallel pulses and which image gate receives the line-sum pulse. Every pulse slot is four sub-cycles long, and each sub-cycle lasts a derived number of clocks, so no gate toggles faster than 12.5 MHz. The clear width is stretched by the same kind of derivation so that it lasts at least 1 µs.

Top module: `ccd_ft_timing_gen`

## Requirements
- R1: A frame runs clear, integrate, (line-sum), transfer, readout in that order. `frame_start` is high for exactly the first clock of the clear phase. `mode` and `integ_len` are sampled only at the clock edge that ends that cycle, and changes at any other time have no effect on the frame in progress.
- R2: `clear_n` (active low) is low for CLR_CYC = max(CLEAR_CYCLES, ceil(1 000 000 / CLK_PERIOD_PS)) clocks per frame. While it is low, every other strobe and `line_valid` are low.
- R3: Integration follows the clear phase and lasts max(integ_len, 1) clocks, with `clear_n` high and every strobe low.
- R4: Every pulse slot lasts 4·DIV clocks, where DIV = max(1, ceil(80 000 / (4·CLK_PERIOD_PS))). A parallel-type pulse is high for the first 2·DIV clocks of its slot. Rising edges of `srg2` are at least 4·DIV clocks apart.
- R5: The mode encoding is 0 interlaced, 1 progressive single-register, 2 progressive dual-register, 3 line-summing. In modes 0 and 3 the transfer issues LINES+field slots. In modes 1 and 2 it issues LINES slots. Each transfer slot pulses `iag1`, `iag2` and `sag`; it also pulses `srg2` in mode 0 and both `srg1` and `srg2` in mode 3.
- R6: In mode 3 only, one slot comes before the transfer. That slot pulses `iag1` alone when field is 0 and `iag2` alone when field is 1.
- R7: Readout covers LINES lines in mode 1 and LINES/2 lines in the other modes. Each line is one slot pulsing `sag`, followed by PIX pixel slots. `line_valid` is high during the pixel slots only.
- R8: A pixel slot drives `rst_gate` in sub-cycle 0, `clamp` in sub-cycle 1, the serial gate in sub-cycle 2 and `sh` in sub-cycle 3. Each lasts DIV clocks, and no two of them overlap.
- R9: Pixel readout always clocks `srg2`. It also clocks `srg1` in modes 2 and 3. `srg1` is never high without `srg2`.
- R10: `field` is 0 after reset. It inverts on the edge that enters the clear phase of each following frame and is stable for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Readout scheme, sampled at frame start |
| integ_len | input | INTEG_W | Integration length in clocks, sampled at frame start |
| clear_n | output | 1 | Overflow-drain clear strobe, active low |
| frame_start | output | 1 | One-clock pulse at the start of the clear phase |
| iag1 | output | 1 | Image-area gate strobe 1 |
| iag2 | output | 1 | Image-area gate strobe 2 |
| sag | output | 1 | Storage-area gate strobe |
| srg1 | output | 1 | Serial gate strobe, register 1 |
| srg2 | output | 1 | Serial gate strobe, register 2 |
| rst_gate | output | 1 | Detection-node reset strobe |
| clamp | output | 1 | Reset-level clamp strobe |
| sh | output | 1 | Signal-level sample-and-hold strobe |
| line_valid | output | 1 | High while a line's pixels are read |
| field | output | 1 | Current field (0 or 1) |

## Verification
The bench targets the field-dependent pulse count. A design that ignored the field would give interlaced and line-summing frames one parallel pulse too few on odd fields, and the per-clock comparison would see a frame that ends 4·DIV clocks early. The line-sum frames alternate fields, so routing the sum pulse to the wrong image gate shows up at once. Integration lengths of 0 and 1 test the one-clock minimum. Mid-frame changes to the mode and integration inputs catch a design that samples them outside frame start, because such a design would change the line count or the register selection of the running frame. Dual-register and line-summing frames check that `srg1` joins `srg2`, and single-register frames check that it stays idle.

// File: rtl/ccd_ft_pkg.sv
`timescale 1ns/1ps
package ccd_ft_pkg;

    typedef enum logic [1:0] {
        MODE_INTERLACED  = 2'd0,
        MODE_PROG_SINGLE = 2'd1,
        MODE_PROG_DUAL   = 2'd2,
        MODE_LINE_SUM    = 2'd3
    } readout_mode_e;

    typedef enum logic [2:0] {
        PH_CLEAR  = 3'd0,
        PH_INTEG  = 3'd1,
        PH_SUM    = 3'd2,
        PH_XFER   = 3'd3,
        PH_LSHIFT = 3'd4,
        PH_PIXEL  = 3'd5
    } phase_e;

    typedef struct packed {
        logic clear_n;
        logic iag1;
        logic iag2;
        logic sag;
        logic srg1;
        logic srg2;
        logic rst_gate;
        logic clamp;
        logic sh;
        logic line_valid;
    } gate_vec_t;

    localparam int unsigned SUBS_PER_SLOT      = 4;
    localparam int unsigned GATE_MIN_PERIOD_PS = 80000;
    localparam int unsigned CLEAR_MIN_PS       = 1000000;

    function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic int unsigned clear_cycles(input int unsigned req, input int unsigned period_ps);
        int unsigned floor_cyc;
        floor_cyc = ceil_div(CLEAR_MIN_PS, period_ps);
        if (req > floor_cyc) floor_cyc = req;
        if (floor_cyc == 0) floor_cyc = 1;
        return floor_cyc;
    endfunction

    function automatic int unsigned tick_div(input int unsigned period_ps);
        int unsigned d;
        d = ceil_div(GATE_MIN_PERIOD_PS, SUBS_PER_SLOT * period_ps);
        if (d == 0) d = 1;
        return d;
    endfunction

    function automatic logic is_progressive(input readout_mode_e m);
        return (m == MODE_PROG_SINGLE) || (m == MODE_PROG_DUAL);
    endfunction

    function automatic logic pixel_uses_reg1(input readout_mode_e m);
        return (m == MODE_PROG_DUAL) || (m == MODE_LINE_SUM);
    endfunction

endpackage

// File: rtl/ccd_ft_tick.sv
`timescale 1ns/1ps
module ccd_ft_tick #(
    parameter int unsigned DIV = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [1:0] sub,
    output logic       slot_last
);

    generate
        if (DIV == 1) begin : g_nodiv
            always_ff @(posedge clk) begin
                if (rst || !en) sub <= 2'd0;
                else            sub <= sub + 2'd1;
            end
            assign slot_last = en && (sub == 2'd3);
        end else begin : g_div
            localparam int unsigned DW = $clog2(DIV);
            localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
            logic [DW-1:0] div_cnt;

            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    div_cnt <= '0;
                    sub     <= 2'd0;
                end else if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                    sub     <= sub + 2'd1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
            assign slot_last = en && (sub == 2'd3) && (div_cnt == DIV_LAST);
        end
    endgenerate

endmodule

// File: rtl/ccd_ft_seq.sv
`timescale 1ns/1ps
module ccd_ft_seq
    import ccd_ft_pkg::*;
#(
    parameter int unsigned LINES   = 500,
    parameter int unsigned PIX     = 684,
    parameter int unsigned INTEG_W = 20,
    parameter int unsigned CLR_CYC = 125
) (
    input  logic               clk,
    input  logic               rst,
    input  readout_mode_e      mode_in,
    input  logic [INTEG_W-1:0] integ_len,
    input  logic               slot_last,
    output phase_e             phase,
    output readout_mode_e      mode_q,
    output logic               field,
    output logic               frame_start,
    output logic               slot_en
);

    localparam int unsigned CLR_W  = $clog2(CLR_CYC + 1);
    localparam int unsigned CYC_W  = ((INTEG_W > CLR_W) ? INTEG_W : CLR_W) + 1;
    localparam int unsigned CNT_MX = ((LINES + 1) > PIX) ? (LINES + 1) : PIX;
    localparam int unsigned CNT_W  = $clog2(CNT_MX + 1);
    localparam int unsigned LCNT_W = $clog2(LINES + 1);

    logic [CYC_W-1:0]   cyc;
    logic [INTEG_W-1:0] integ_q;
    logic [CNT_W-1:0]   cnt;
    logic [LCNT_W-1:0]  line;

    logic [CNT_W-1:0]   xfer_last;
    logic [LCNT_W-1:0]  line_last;
    logic               clear_done;
    logic               integ_done;

    always_comb begin
        if (is_progressive(mode_q))
            xfer_last = CNT_W'(LINES - 1);
        else
            xfer_last = CNT_W'(LINES - 1) + {{(CNT_W-1){1'b0}}, field};
        if (mode_q == MODE_PROG_SINGLE)
            line_last = LCNT_W'(LINES - 1);
        else
            line_last = LCNT_W'(LINES / 2 - 1);
        clear_done  = (cyc == CYC_W'(CLR_CYC - 1));
        integ_done  = ((cyc + CYC_W'(1)) >= CYC_W'(integ_q));
        frame_start = (phase == PH_CLEAR) && (cyc == '0);
        slot_en     = (phase == PH_SUM) || (phase == PH_XFER) ||
                      (phase == PH_LSHIFT) || (phase == PH_PIXEL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_CLEAR;
            mode_q  <= MODE_INTERLACED;
            integ_q <= '0;
            field   <= 1'b0;
            cyc     <= '0;
            cnt     <= '0;
            line    <= '0;
        end else begin
            unique case (phase)
                PH_CLEAR: begin
                    if (cyc == '0) begin
                        mode_q  <= mode_in;
                        integ_q <= integ_len;
                    end
                    if (clear_done) begin
                        phase <= PH_INTEG;
                        cyc   <= '0;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                PH_INTEG: begin
                    if (integ_done) begin
                        phase <= (mode_q == MODE_LINE_SUM) ? PH_SUM : PH_XFER;
                        cnt   <= '0;
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                PH_SUM: begin
                    if (slot_last) begin
                        phase <= PH_XFER;
                        cnt   <= '0;
                    end
                end
                PH_XFER: begin
                    if (slot_last) begin
                        if (cnt == xfer_last) begin
                            phase <= PH_LSHIFT;
                            cnt   <= '0;
                            line  <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_LSHIFT: begin
                    if (slot_last) begin
                        phase <= PH_PIXEL;
                        cnt   <= '0;
                    end
                end
                PH_PIXEL: begin
                    if (slot_last) begin
                        if (cnt == CNT_W'(PIX - 1)) begin
                            cnt <= '0;
                            if (line == line_last) begin
                                phase <= PH_CLEAR;
                                cyc   <= '0;
                                field <= ~field;
                            end else begin
                                line  <= line + 1'b1;
                                phase <= PH_LSHIFT;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_CLEAR;
            endcase
        end
    end

endmodule

// File: rtl/ccd_ft_decode.sv
`timescale 1ns/1ps
module ccd_ft_decode
    import ccd_ft_pkg::*;
(
    input  phase_e        phase,
    input  logic [1:0]    sub,
    input  readout_mode_e mode_q,
    input  logic          field,
    output gate_vec_t     gates
);

    logic first_half;

    always_comb begin
        first_half    = ~sub[1];
        gates         = '0;
        gates.clear_n = (phase != PH_CLEAR);
        unique case (phase)
            PH_SUM: begin
                gates.iag1 = first_half && !field;
                gates.iag2 = first_half &&  field;
            end
            PH_XFER: begin
                gates.iag1 = first_half;
                gates.iag2 = first_half;
                gates.sag  = first_half;
                gates.srg2 = first_half && !is_progressive(mode_q);
                gates.srg1 = first_half && (mode_q == MODE_LINE_SUM);
            end
            PH_LSHIFT: begin
                gates.sag = first_half;
            end
            PH_PIXEL: begin
                gates.line_valid = 1'b1;
                gates.rst_gate   = (sub == 2'd0);
                gates.clamp      = (sub == 2'd1);
                gates.srg2       = (sub == 2'd2);
                gates.srg1       = (sub == 2'd2) && pixel_uses_reg1(mode_q);
                gates.sh         = (sub == 2'd3);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ccd_ft_timing_gen.sv
`timescale 1ns/1ps
module ccd_ft_timing_gen
    import ccd_ft_pkg::*;
#(
    parameter int unsigned LINES         = 500,
    parameter int unsigned PIX           = 684,
    parameter int unsigned INTEG_W       = 20,
    parameter int unsigned CLEAR_CYCLES  = 1,
    parameter int unsigned CLK_PERIOD_PS = 8000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode,
    input  logic [INTEG_W-1:0] integ_len,
    output logic               clear_n,
    output logic               frame_start,
    output logic               iag1,
    output logic               iag2,
    output logic               sag,
    output logic               srg1,
    output logic               srg2,
    output logic               rst_gate,
    output logic               clamp,
    output logic               sh,
    output logic               line_valid,
    output logic               field
);

    localparam int unsigned CLR_CYC = clear_cycles(CLEAR_CYCLES, CLK_PERIOD_PS);
    localparam int unsigned DIV     = tick_div(CLK_PERIOD_PS);

    phase_e        phase;
    readout_mode_e mode_q;
    logic [1:0]    sub;
    logic          slot_last;
    logic          slot_en;
    gate_vec_t     gates;

    ccd_ft_tick #(.DIV(DIV)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .en        (slot_en),
        .sub       (sub),
        .slot_last (slot_last)
    );

    ccd_ft_seq #(
        .LINES   (LINES),
        .PIX     (PIX),
        .INTEG_W (INTEG_W),
        .CLR_CYC (CLR_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .mode_in     (readout_mode_e'(mode)),
        .integ_len   (integ_len),
        .slot_last   (slot_last),
        .phase       (phase),
        .mode_q      (mode_q),
        .field       (field),
        .frame_start (frame_start),
        .slot_en     (slot_en)
    );

    ccd_ft_decode u_dec (
        .phase  (phase),
        .sub    (sub),
        .mode_q (mode_q),
        .field  (field),
        .gates  (gates)
    );

    assign clear_n    = gates.clear_n;
    assign iag1       = gates.iag1;
    assign iag2       = gates.iag2;
    assign sag        = gates.sag;
    assign srg1       = gates.srg1;
    assign srg2       = gates.srg2;
    assign rst_gate   = gates.rst_gate;
    assign clamp      = gates.clamp;
    assign sh         = gates.sh;
    assign line_valid = gates.line_valid;

endmodule

// File: rtl/ccd_ft_checker.sv
`timescale 1ns/1ps
module ccd_ft_checker
    import ccd_ft_pkg::*;
#(
    parameter int unsigned CLEAR_CYCLES  = 1,
    parameter int unsigned CLK_PERIOD_PS = 8000
) (
    input logic clk,
    input logic rst,
    input logic clear_n,
    input logic frame_start,
    input logic iag1,
    input logic iag2,
    input logic sag,
    input logic srg1,
    input logic srg2,
    input logic rst_gate,
    input logic clamp,
    input logic sh,
    input logic line_valid,
    input logic field
);

    localparam int unsigned CLR_CYC = clear_cycles(CLEAR_CYCLES, CLK_PERIOD_PS);
    localparam int unsigned DIV     = tick_div(CLK_PERIOD_PS);
    localparam int unsigned LW      = $clog2(CLR_CYC + 1);
    localparam int unsigned GAP_MAX = 4 * DIV;
    localparam int unsigned GW      = $clog2(GAP_MAX + 1);

    logic [LW-1:0] low_cnt;
    logic [GW-1:0] gap_cnt;
    logic          srg2_d;
    logic          seen_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            gap_cnt   <= '0;
            srg2_d    <= 1'b0;
            seen_rise <= 1'b0;
        end else begin
            if (!clear_n) begin
                if (low_cnt != LW'(CLR_CYC)) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
            srg2_d <= srg2;
            if (srg2 && !srg2_d) begin
                gap_cnt   <= GW'(1);
                seen_rise <= 1'b1;
            end else if (gap_cnt != GW'(GAP_MAX)) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    assert_start_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    assert_clear_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(clear_n) |-> (low_cnt >= LW'(CLR_CYC)));

    assert_quiet_in_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> !(iag1 || iag2 || sag || srg1 || srg2 || rst_gate || clamp || sh || line_valid));

    assert_gate_rate_R4: assert property (@(posedge clk) disable iff (rst)
        (srg2 && !srg2_d && seen_rise) |-> (gap_cnt >= GW'(GAP_MAX)));

    assert_sum_single_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (iag1 != iag2) |-> (!sag && !srg2));

    assert_readout_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> !(iag1 || iag2 || sag));

    assert_pixel_order_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_gate, clamp, sh, srg2 && line_valid}));

    assert_reg1_paired_R9: assert property (@(posedge clk) disable iff (rst)
        srg1 |-> srg2);

    assert_field_change_R10: assert property (@(posedge clk) disable iff (rst)
        (field != $past(field)) |-> frame_start);

endmodule

bind ccd_ft_timing_gen ccd_ft_checker #(
    .CLEAR_CYCLES  (CLEAR_CYCLES),
    .CLK_PERIOD_PS (CLK_PERIOD_PS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear_n     (clear_n),
    .frame_start (frame_start),
    .iag1        (iag1),
    .iag2        (iag2),
    .sag         (sag),
    .srg1        (srg1),
    .srg2        (srg2),
    .rst_gate    (rst_gate),
    .clamp       (clamp),
    .sh          (sh),
    .line_valid  (line_valid),
    .field       (field)
);

// File: tb/sim_ccd_ft_timing_gen.sv
`timescale 1ns/1ps
module sim_ccd_ft_timing_gen;

    localparam int LINES   = 4;
    localparam int PIX     = 3;
    localparam int INTEG_W = 8;
    // From R2 and R4 with an 8000 ps clock: ceil(1e6/8000)=125, ceil(80000/32000)=3
    localparam int E_CLR   = 125;
    localparam int E_DIV   = 3;
    localparam int NFRAMES = 8;

    // bench vector bit positions
    localparam int B_CN = 11, B_FS = 10, B_I1 = 9, B_I2 = 8, B_SAG = 7, B_S1 = 6,
                   B_S2 = 5, B_RG = 4, B_CL = 3, B_SH = 2, B_LV = 1, B_FLD = 0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic [INTEG_W-1:0] integ_len = '0;
    logic clear_n, frame_start, iag1, iag2, sag, srg1, srg2, rst_gate, clamp, sh, line_valid, field;

    always #4 clk = ~clk;

    ccd_ft_timing_gen #(
        .LINES(LINES), .PIX(PIX), .INTEG_W(INTEG_W),
        .CLEAR_CYCLES(2), .CLK_PERIOD_PS(8000)
    ) u0 (
        .clk(clk), .rst(rst), .mode(mode), .integ_len(integ_len),
        .clear_n(clear_n), .frame_start(frame_start), .iag1(iag1), .iag2(iag2),
        .sag(sag), .srg1(srg1), .srg2(srg2), .rst_gate(rst_gate), .clamp(clamp),
        .sh(sh), .line_valid(line_valid), .field(field)
    );

    logic [11:0] exp_q[$];
    int checks = 0;
    int fails = 0;
    bit bench_field = 1'b0;
    bit finished = 1'b0;
    int frame_idx = 0;
    int fcyc = 0;
    int tbl_mode[NFRAMES]  = '{0, 0, 3, 3, 1, 2, 2, 1};
    int tbl_integ[NFRAMES] = '{5, 0, 1, 7, 3, 2, 9, 4};

    function automatic string tag_of(input int b);
        case (b)
            B_CN:       return "R2 R3 clear_n";
            B_FS:       return "R1 frame_start";
            B_I1, B_I2: return "R5 R6 image gate";
            B_SAG:      return "R4 R5 R7 sag";
            B_S1:       return "R9 srg1";
            B_S2:       return "R4 R8 R9 srg2";
            B_LV:       return "R7 line_valid";
            B_FLD:      return "R10 field";
            default:    return "R8 pixel strobe";
        endcase
    endfunction

    function automatic logic [11:0] dut_vec();
        return {clear_n, frame_start, iag1, iag2, sag, srg1, srg2,
                rst_gate, clamp, sh, line_valid, field};
    endfunction

    task automatic push(input logic [11:0] v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    task automatic push_slot(input logic [11:0] hi, input logic [11:0] base);
        push(hi, 2 * E_DIV);
        push(base, 2 * E_DIV);
    endtask

    // R1..R10 reference frame
    task automatic build_frame(input int m, input int ig);
        logic [11:0] fb, base, xb, pb;
        int nx, nl;
        fb = {11'b0, bench_field};
        push(fb | (12'b1 << B_FS), 1);
        push(fb, E_CLR - 1);
        base = fb | (12'b1 << B_CN);
        push(base, (ig < 1) ? 1 : ig);
        if (m == 3)
            push_slot(base | (12'b1 << (bench_field ? B_I2 : B_I1)), base);
        nx = (m == 1 || m == 2) ? LINES : LINES + int'(bench_field);
        xb = base | (12'b1 << B_I1) | (12'b1 << B_I2) | (12'b1 << B_SAG);
        if (m == 0) xb = xb | (12'b1 << B_S2);
        if (m == 3) xb = xb | (12'b1 << B_S2) | (12'b1 << B_S1);
        for (int i = 0; i < nx; i++) push_slot(xb, base);
        nl = (m == 1) ? LINES : LINES / 2;
        for (int l = 0; l < nl; l++) begin
            push_slot(base | (12'b1 << B_SAG), base);
            pb = base | (12'b1 << B_LV);
            for (int p = 0; p < PIX; p++) begin
                push(pb | (12'b1 << B_RG), E_DIV);
                push(pb | (12'b1 << B_CL), E_DIV);
                push(pb | (12'b1 << B_S2) | ((m >= 2) ? (12'b1 << B_S1) : 12'b0), E_DIV);
                push(pb | (12'b1 << B_SH), E_DIV);
            end
        end
        bench_field = ~bench_field;
    endtask

    task automatic compare(input logic [11:0] expv);
        logic [11:0] got;
        got = dut_vec();
        checks++;
        if (got !== expv) begin
            fails++;
            for (int b = 11; b >= 0; b--) begin
                if (got[b] !== expv[b]) begin
                    $display("FAIL %s frame %0d cycle %0d: got %b expected %b",
                             tag_of(b), frame_idx - 1, fcyc, got, expv);
                    break;
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: R2 clear held low, R7 no readout, R10 field zero
        checks++;
        if ({clear_n, iag1, iag2, sag, srg1, srg2, rst_gate, clamp, sh, line_valid, field} !== 11'b0) begin
            fails++;
            $display("FAIL R2 R10 reset state: got %b expected %b",
                     {clear_n, iag1, iag2, sag, srg1, srg2, rst_gate, clamp, sh, line_valid, field}, 11'b0);
        end
        rst = 1'b0;
        forever begin
            if (exp_q.size() == 0) begin
                if (frame_idx == NFRAMES) break;
                mode      = 2'(tbl_mode[frame_idx]);
                integ_len = INTEG_W'(tbl_integ[frame_idx]);
                build_frame(tbl_mode[frame_idx], tbl_integ[frame_idx]);
                frame_idx++;
                fcyc = 0;
            end
            // R1: inputs changed mid-frame must be ignored
            if (fcyc == 150) begin
                mode      = mode + 2'd1;
                integ_len = 8'd33;
            end
            compare(exp_q.pop_front());
            fcyc++;
            @(negedge clk);
        end
        // R1: next frame begins right after the last readout
        checks++;
        if (!(frame_start === 1'b1 && clear_n === 1'b0)) begin
            fails++;
            $display("FAIL R1 next frame start: got fs=%b cn=%b expected fs=1 cn=0",
                     frame_start, clear_n);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog: got no end expected run to finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule